// File: doc/BRIEF.md
# Programmable Event Counter Bank

A bank of general-purpose event counters for performance monitoring. Each cycle, a vector of event lanes reports how many times each event source occurred, from 0 to 4 per lane. Each counter has its own configuration word. The word picks one source by a 16-bit selector: an 8-bit event code and an 8-bit unit mask, compared against a parameter table. The word also sets which privilege modes count and whether the counter is locally enabled. It can ask for an interrupt on overflow, and it can set a threshold that turns the counter into a count of the cycles in which at least N events occurred.

A global control register gates each counter with one bit. A sticky overflow status register records every wraparound at the same bit index. A clear register removes status bits wherever a one is written. Software can rewrite a running counter at any time. It can preset the counter so that it wraps after a known number of events.

Top module: `perf_event_bank`

## Requirements
- R1: After synchronous reset, every counter, configuration, the global control and the overflow status read as zero, and `irq_o` is low.
- R2: Configuration bits [15:0] select a source. If they equal table entry s (by default 0x0011, 0x0022, 0x0133 and 0x0044 for lanes 0 to 3), the count on lane s is used. A selector that matches no entry adds nothing.
- R3: A counter advances only while its configuration enable bit (bit 16) and its own bit in the global control register are both set.
- R4: Configuration bit 17 allows counting while `priv_user` is 1, and bit 18 allows counting while `priv_user` is 0.
- R5: When threshold bits [23:20] are zero, the counter adds the lane count. When they hold N > 0, the counter adds 1 in each cycle whose lane count is at least N, and adds 0 otherwise.
- R6: A write to a counter appears at the next edge and replaces that cycle's increment. Counting then resumes from the written value.
- R7: When a counter carries past its all-ones value, it keeps the low CTR_W bits and sets its status bit. That bit stays set until it is cleared.
- R8: A write to the clear register clears exactly the status bits written as one and leaves the others unchanged.
- R9: `irq_o` is a one-cycle pulse in the cycle after a wrap, and only for a counter whose configuration bit 19 is set.
- R10: Register map for both reads and writes: address i is counter i, address NUM_CTR+i is configuration i, address 2·NUM_CTR is global control, address 2·NUM_CTR+1 is status (read only), and address 2·NUM_CTR+2 is clear (write only). With 4 counters these are 0–3, 4–7, 8, 9 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | CTR_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | CTR_W | Read data, combinational from the registers |
| priv_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| evt_lanes | input | NUM_SRC·LANE_W | Per-source event count for this cycle |
| irq_o | output | 1 | Overflow interrupt pulse |

## Verification
Register writes, event increments and status updates are captured at one clock edge, and reads are combinational. Every value is therefore due one edge after its stimulus. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and reads the result on the next falling edge. The interrupt is registered, so it is due in that same sampling slot after the wrapping edge. The bench checks it there as high and checks it one cycle later as low again. The cycle-exact cases are checked in that slot: a rewrite of a running counter that collides with an event, and a preset counter wrapping on a particular event.

// File: rtl/pev_pkg.sv
// Package: configuration field layout and register address helpers shared
// by the counter bank and its checker.
package pev_pkg;
    localparam int CFG_W   = 24;
    localparam int SEL_LSB = 0;
    localparam int SEL_W   = 16;
    localparam int EN_BIT  = 16;
    localparam int USR_BIT = 17;
    localparam int OS_BIT  = 18;
    localparam int IE_BIT  = 19;
    localparam int TH_LSB  = 20;
    localparam int TH_W    = 4;

    // Address of configuration register i.
    function automatic int cfg_addr(input int n_ctr, input int i);
        return n_ctr + i;
    endfunction
    // Address of the global control register.
    function automatic int ctl_addr(input int n_ctr);
        return 2 * n_ctr;
    endfunction
    // Address of the overflow status register.
    function automatic int sts_addr(input int n_ctr);
        return 2 * n_ctr + 1;
    endfunction
    // Address of the status-clear register.
    function automatic int clr_addr(input int n_ctr);
        return 2 * n_ctr + 2;
    endfunction
endpackage

// File: rtl/pev_evt_select.sv
// pev_evt_select: turns one configuration word and the event lanes into
// this cycle's increment. It picks the lane by table match, applies the
// privilege and enable qualifiers, and applies the threshold.
// Assumes: purely combinational, and the lowest table index wins if two
// entries are equal.
module pev_evt_select
    import pev_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int LANE_W  = 3,
    parameter logic [NUM_SRC*SEL_W-1:0] SRC_CODES = '0
) (
    input  logic [CFG_W-1:0]          cfg_i,
    input  logic [NUM_SRC*LANE_W-1:0] lanes_i,
    input  logic                      priv_user_i,
    input  logic                      gate_i,
    output logic [LANE_W-1:0]         inc_o
);
    localparam int CMP_W = (LANE_W > TH_W ? LANE_W : TH_W) + 1;

    logic [LANE_W-1:0] lane_val;
    logic [TH_W-1:0]   thresh;
    logic              mode_ok;
    logic              run;

    // Pick the lane whose table code equals the selector.
    always_comb begin
        lane_val = '0;
        for (int s = NUM_SRC - 1; s >= 0; s--) begin
            if (cfg_i[SEL_LSB +: SEL_W] == SRC_CODES[s*SEL_W +: SEL_W])
                lane_val = lanes_i[s*LANE_W +: LANE_W];
        end
    end

    // Qualify by privilege, local enable, global gate and threshold.
    always_comb begin
        thresh  = cfg_i[TH_LSB +: TH_W];
        mode_ok = priv_user_i ? cfg_i[USR_BIT] : cfg_i[OS_BIT];
        run     = cfg_i[EN_BIT] & gate_i & mode_ok;
        inc_o   = '0;
        if (run) begin
            if (thresh == '0)
                inc_o = lane_val;
            else if (CMP_W'(lane_val) >= CMP_W'(thresh))
                inc_o = LANE_W'(1);
        end
    end
endmodule

// File: rtl/pev_ctr_slice.sv
// pev_ctr_slice: one counter with its configuration register. It accepts
// software writes to either register. A counter write takes priority over
// the increment of the same cycle. It reports a wrap when the addition
// carries out of CTR_W bits.
// Assumes: wr_data is at least CFG_W wide.
module pev_ctr_slice
    import pev_pkg::*;
#(
    parameter int IDX     = 0,
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 48,
    parameter int ADDR_W  = 4,
    parameter int NUM_SRC = 4,
    parameter int LANE_W  = 3,
    parameter logic [NUM_SRC*SEL_W-1:0] SRC_CODES = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [CTR_W-1:0]          wr_data,
    input  logic                      priv_user,
    input  logic                      gate,
    input  logic [NUM_SRC*LANE_W-1:0] lanes,
    output logic [CTR_W-1:0]          cnt_o,
    output logic [CFG_W-1:0]          cfg_o,
    output logic                      irq_en_o,
    output logic                      wrap_o
);
    logic [CFG_W-1:0]  cfg_q;
    logic [CTR_W-1:0]  cnt_q;
    logic [LANE_W-1:0] inc;
    logic [CTR_W:0]    sum;
    logic              cnt_wr;
    logic              cfg_wr;
    logic [CTR_W-1:0]  wr_hi_unused;

    pev_evt_select #(
        .NUM_SRC  (NUM_SRC),
        .LANE_W   (LANE_W),
        .SRC_CODES(SRC_CODES)
    ) u_sel (
        .cfg_i      (cfg_q),
        .lanes_i    (lanes),
        .priv_user_i(priv_user),
        .gate_i     (gate),
        .inc_o      (inc)
    );

    // Decode writes and form the next count with its carry.
    always_comb begin
        cnt_wr       = wr_en && (wr_addr == ADDR_W'(IDX));
        cfg_wr       = wr_en && (wr_addr == ADDR_W'(cfg_addr(NUM_CTR, IDX)));
        sum          = {1'b0, cnt_q} + (CTR_W + 1)'(inc);
        wrap_o       = !cnt_wr && sum[CTR_W];
        wr_hi_unused = wr_data;
    end

    // Configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (cfg_wr)
            cfg_q <= wr_data[CFG_W-1:0];
    end

    // Count register: a software write wins over counting.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_wr)
            cnt_q <= wr_hi_unused;
        else
            cnt_q <= sum[CTR_W-1:0];
    end

    assign cnt_o    = cnt_q;
    assign cfg_o    = cfg_q;
    assign irq_en_o = cfg_q[IE_BIT];
endmodule

// File: rtl/pev_global_regs.sv
// pev_global_regs: the global per-counter gate register, the sticky
// overflow status with write-one-to-clear, and the registered interrupt
// pulse.
// Assumes: a wrap in the same cycle as a clear of that bit leaves the
// bit set, so no overflow is lost.
module pev_global_regs
    import pev_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [NUM_CTR-1:0] wr_bits,
    input  logic [NUM_CTR-1:0] wrap,
    input  logic [NUM_CTR-1:0] irq_en,
    output logic [NUM_CTR-1:0] gctl_o,
    output logic [NUM_CTR-1:0] status_o,
    output logic               irq_o
);
    logic [NUM_CTR-1:0] gctl_q;
    logic [NUM_CTR-1:0] status_q;
    logic [NUM_CTR-1:0] clr_mask;
    logic               irq_q;

    // Clear mask is the written bits on a write to the clear register.
    always_comb begin
        clr_mask = (wr_en && wr_addr == ADDR_W'(clr_addr(NUM_CTR))) ? wr_bits : '0;
    end

    // Global gate register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gctl_q <= '0;
        else if (wr_en && wr_addr == ADDR_W'(ctl_addr(NUM_CTR)))
            gctl_q <= wr_bits;
    end

    // Sticky overflow status; a new wrap wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else
            status_q <= (status_q & ~clr_mask) | wrap;
    end

    // One-cycle interrupt for wraps of counters that opted in.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= |(wrap & irq_en);
    end

    assign gctl_o   = gctl_q;
    assign status_o = status_q;
    assign irq_o    = irq_q;
endmodule

// File: rtl/perf_event_bank.sv
// perf_event_bank: top of the event counter bank. It instantiates one slice
// per counter and the global registers, and muxes the register read-back.
// Assumes: CTR_W >= CFG_W and CTR_W >= NUM_CTR. Reads are combinational.
module perf_event_bank
    import pev_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 48,
    parameter int NUM_SRC = 4,
    parameter int LANE_W  = 3,
    parameter logic [NUM_SRC*SEL_W-1:0] SRC_CODES =
        {16'h0044, 16'h0133, 16'h0022, 16'h0011},
    localparam int ADDR_W = $clog2(2 * NUM_CTR + 3)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [CTR_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [CTR_W-1:0]          rd_data,
    input  logic                      priv_user,
    input  logic [NUM_SRC*LANE_W-1:0] evt_lanes,
    output logic                      irq_o
);
    logic [CTR_W-1:0]         cnt [NUM_CTR];
    logic [CFG_W-1:0]         cfg [NUM_CTR];
    logic [NUM_CTR*CTR_W-1:0] cnt_flat;
    logic [NUM_CTR-1:0]       irq_en;
    logic [NUM_CTR-1:0]       wrap;
    logic [NUM_CTR-1:0]       gctl;
    logic [NUM_CTR-1:0]       status;

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_slice
        pev_ctr_slice #(
            .IDX      (i),
            .NUM_CTR  (NUM_CTR),
            .CTR_W    (CTR_W),
            .ADDR_W   (ADDR_W),
            .NUM_SRC  (NUM_SRC),
            .LANE_W   (LANE_W),
            .SRC_CODES(SRC_CODES)
        ) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en),
            .wr_addr  (wr_addr),
            .wr_data  (wr_data),
            .priv_user(priv_user),
            .gate     (gctl[i]),
            .lanes    (evt_lanes),
            .cnt_o    (cnt[i]),
            .cfg_o    (cfg[i]),
            .irq_en_o (irq_en[i]),
            .wrap_o   (wrap[i])
        );
        assign cnt_flat[i*CTR_W +: CTR_W] = cnt[i];
    end

    pev_global_regs #(
        .NUM_CTR(NUM_CTR),
        .ADDR_W (ADDR_W)
    ) u_glob (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_bits (wr_data[NUM_CTR-1:0]),
        .wrap    (wrap),
        .irq_en  (irq_en),
        .gctl_o  (gctl),
        .status_o(status),
        .irq_o   (irq_o)
    );

    // Read-back multiplexer over the register map.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (rd_addr == ADDR_W'(i))
                rd_data = cnt[i];
            if (rd_addr == ADDR_W'(cfg_addr(NUM_CTR, i)))
                rd_data = CTR_W'(cfg[i]);
        end
        if (rd_addr == ADDR_W'(ctl_addr(NUM_CTR)))
            rd_data = CTR_W'(gctl);
        if (rd_addr == ADDR_W'(sts_addr(NUM_CTR)))
            rd_data = CTR_W'(status);
    end
endmodule

// File: rtl/perf_event_bank_chk.sv
// perf_event_bank_chk: temporal properties of the counter bank, attached
// to the top module by bind.
// Assumes: sees internal gate, status, wrap and counter values.
module perf_event_bank_chk
    import pev_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 48,
    parameter int ADDR_W  = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [ADDR_W-1:0]        wr_addr,
    input logic [CTR_W-1:0]         wr_data,
    input logic [NUM_CTR-1:0]       gctl,
    input logic [NUM_CTR-1:0]       status,
    input logic [NUM_CTR-1:0]       wrap,
    input logic [NUM_CTR-1:0]       irq_en,
    input logic [NUM_CTR*CTR_W-1:0] cnt_flat,
    input logic                     irq_o
);
    logic clr_wr;
    assign clr_wr = wr_en && (wr_addr == ADDR_W'(clr_addr(NUM_CTR)));

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_prop
        AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!gctl[i] && !(wr_en && wr_addr == ADDR_W'(i))) |=> $stable(cnt_flat[i*CTR_W +: CTR_W])); // R3
        AST_WRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            wrap[i] |=> status[i]); // R7
        AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (status[i] && !(clr_wr && wr_data[i])) |=> status[i]); // R7
        AST_CLEAR_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr && wr_data[i] && !wrap[i]) |=> !status[i]); // R8
    end

    AST_IRQ_OPTIN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|(wrap & irq_en))); // R9
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(wrap & irq_en)) |=> irq_o); // R9
endmodule

bind perf_event_bank perf_event_bank_chk #(
    .NUM_CTR(NUM_CTR),
    .CTR_W  (CTR_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .gctl    (gctl),
    .status  (status),
    .wrap    (wrap),
    .irq_en  (irq_en),
    .cnt_flat(cnt_flat),
    .irq_o   (irq_o)
);

// File: tb/perf_event_bank_bench.sv
// Directed bench for perf_event_bank: one task per scenario.
module perf_event_bank_bench;
    localparam int NC = 4;
    localparam int W  = 48;
    localparam int AW = 4;
    localparam logic [W-1:0] ONES = {W{1'b1}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [W-1:0]  rd_data;
    logic          priv_user = 1'b1;
    logic [11:0]   evt_lanes = '0;
    logic          irq_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    perf_event_bank u_perf_event_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .priv_user(priv_user), .evt_lanes(evt_lanes), .irq_o(irq_o)
    );

    function automatic logic [W-1:0] mkcfg(input logic [15:0] sel, input logic en,
                                           input logic usr, input logic os,
                                           input logic ie, input logic [3:0] th);
        return W'({th, ie, os, usr, en, sel});
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Called on a falling edge; returns on the next falling edge.
    task automatic wr(input int a, input logic [W-1:0] d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [W-1:0] d);
        rd_addr = AW'(a); #1; d = rd_data;
    endtask

    task automatic evt(input logic [11:0] l);
        evt_lanes = l;
        @(posedge clk); @(negedge clk);
        evt_lanes = '0;
    endtask

    task automatic t_reset;
        logic [W-1:0] d;
        for (int a = 0; a < 10; a++) begin
            rd(a, d); chk("R1 reset register", d, '0);
        end
        chk("R1 reset irq", W'(irq_o), '0);
    endtask

    task automatic t_select;
        logic [W-1:0] d;
        wr(4, mkcfg(16'h0011, 1, 1, 1, 0, 0));
        wr(5, mkcfg(16'h0099, 1, 1, 1, 0, 0));
        wr(8, W'(4'b0011));
        rd(4, d); chk("R10 cfg readback", d, mkcfg(16'h0011, 1, 1, 1, 0, 0));
        rd(8, d); chk("R10 ctrl readback", d, W'(4'b0011));
        evt({3'd0, 3'd0, 3'd4, 3'd3});
        evt({3'd0, 3'd0, 3'd4, 3'd3});
        rd(0, d); chk("R2 lane0 sum", d, W'(6));
        rd(1, d); chk("R2 unmatched selector adds nothing", d, '0);
    endtask

    task automatic t_gate;
        logic [W-1:0] d;
        wr(8, W'(4'b0010));
        evt(12'd2);
        rd(0, d); chk("R3 global gate off", d, W'(6));
        wr(8, W'(4'b0001));
        wr(4, mkcfg(16'h0011, 0, 1, 1, 0, 0));
        evt(12'd2);
        rd(0, d); chk("R3 local enable off", d, W'(6));
        wr(4, mkcfg(16'h0011, 1, 1, 1, 0, 0));
        evt(12'd2);
        rd(0, d); chk("R3 both enables on", d, W'(8));
    endtask

    task automatic t_priv;
        logic [W-1:0] d;
        wr(4, mkcfg(16'h0011, 1, 1, 0, 0, 0));
        priv_user = 1'b0;
        evt(12'd3);
        rd(0, d); chk("R4 user-only in supervisor", d, W'(8));
        priv_user = 1'b1;
        evt(12'd3);
        rd(0, d); chk("R4 user-only in user", d, W'(11));
        wr(4, mkcfg(16'h0011, 1, 0, 1, 0, 0));
        evt(12'd1);
        rd(0, d); chk("R4 supervisor-only in user", d, W'(11));
        priv_user = 1'b0;
        evt(12'd1);
        rd(0, d); chk("R4 supervisor-only in supervisor", d, W'(12));
        priv_user = 1'b1;
    endtask

    task automatic t_thresh;
        logic [W-1:0] d;
        wr(0, '0);
        wr(4, mkcfg(16'h0011, 1, 1, 1, 0, 4'd2));
        for (int k = 1; k <= 4; k++) evt(12'(k));
        evt(12'd0);
        rd(0, d); chk("R5 threshold 2 over 1,2,3,4,0", d, W'(3));
    endtask

    task automatic t_rewrite;
        logic [W-1:0] d;
        wr(4, mkcfg(16'h0011, 1, 1, 1, 0, 0));
        evt_lanes = 12'd1;
        wr(0, W'(100));
        rd(0, d); chk("R6 write beats same-cycle event", d, W'(100));
        @(posedge clk); @(negedge clk);
        evt_lanes = '0;
        rd(0, d); chk("R6 counting resumes", d, W'(101));
    endtask

    task automatic t_overflow;
        logic [W-1:0] d;
        wr(6, mkcfg(16'h0022, 1, 1, 1, 0, 0));
        wr(7, mkcfg(16'h0133, 1, 1, 1, 1, 0));
        wr(8, W'(4'b1100));
        wr(2, ONES);
        evt({3'd0, 3'd0, 3'd1, 3'd0});
        rd(2, d); chk("R7 all-ones wraps to zero", d, '0);
        rd(9, d); chk("R7 status bit 2", d, W'(4'b0100));
        chk("R9 no irq without opt-in", W'(irq_o), '0);
        wr(3, ONES - W'(1));
        evt({3'd0, 3'd1, 3'd0, 3'd0});
        chk("R9 no irq before wrap", W'(irq_o), '0);
        evt({3'd0, 3'd1, 3'd0, 3'd0});
        chk("R9 irq pulse on wrap", W'(irq_o), W'(1));
        rd(9, d); chk("R7 status bits 2,3", d, W'(4'b1100));
        evt({3'd0, 3'd1, 3'd0, 3'd0});
        chk("R9 irq is one cycle", W'(irq_o), '0);
        rd(3, d); chk("R7 preset 1-3 reads 1 after 3 events", d, W'(1));
        rd(9, d); chk("R7 status sticky", d, W'(4'b1100));
    endtask

    task automatic t_clear;
        logic [W-1:0] d;
        wr(10, W'(4'b0100));
        rd(9, d); chk("R8 clear bit 2 only", d, W'(4'b1000));
        wr(10, W'(4'b1000));
        rd(9, d); chk("R8 clear bit 3", d, '0);
        chk("R8 no irq from clear", W'(irq_o), '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_select;
        t_gate;
        t_priv;
        t_thresh;
        t_rewrite;
        t_overflow;
        t_clear;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule